// File: doc/BRIEF.md
# Symmetric Rank-K Update Mesh

This block is a square grid of NR×NR processing elements (NR = 4 by default) that updates a symmetric block C in place: C := C + A·Aᵀ, with A an NR×kc panel of signed fixed-point values. Only the lower triangle, diagonal included, is updated. Each element of C lives in the accumulator of its own processing element. Elements talk to each other only over plain data broadcast buses, one per grid row and one per grid column, and each bus transfer takes one cycle.

A job has four steps. The user pulses `start` with the panel width `kc_len`. The user then streams NR rows of initial C values into the accumulators. Next the user streams the kc columns of A. The mesh runs kc+1 update iterations, one per cycle when the input does not stall:
- Column k goes out on the row buses and every element of row r keeps a copy of entry r.
- At the same time each diagonal element re-broadcasts its copy of the previous column on its column bus. This is the on-the-fly transpose.
- The rank-1 update uses that lagged column.

The last iteration only drains the final lagged column. One cycle after it, `done` pulses.

The mesh then streams out the NR rows of C, followed by the kc rows of the transposed panel Aᵀ. The mesh builds Aᵀ in its elements while the job runs.

All three data ports are valid/ready streams:
- A beat transfers on a clock edge where valid and ready are both high.
- The mesh raises each ready only in the phase that uses that port.
- A producer may drop valid at any time, which only delays the job.
- While `c_out_valid` is high and `c_out_ready` is low, the output beat is held unchanged.

Top module: `rank_update_mesh`

## Requirements
- R1: After reset `done`, `c_in_ready`, `col_ready` and `c_out_valid` are all low, and the block waits for `start`.
- R2: A `start` pulse in the idle phase captures `kc_len` and raises `c_in_ready`. The next NR accepted `c_in` beats preload C row by row: beat r sets C[r][c] from bits [c*AW +: AW]. A low `c_in_valid` stalls the load.
- R3: After the preload, `col_ready` is high until kc columns have been accepted. Beat k carries column a_k, with signed entry r in bits [r*DW +: DW]. Gaps in `col_valid` do not change the result. `col_ready` is never high while C is loading.
- R4: At the end of a job, every C[r][c] with r ≥ c equals its preload plus the sum over k of a_k[r]·a_k[c], modulo 2^AW.
- R5: Every C[r][c] with r < c still holds its preloaded value at the end of the job.
- R6: The job runs kc+1 update iterations. `done` is low in the cycle after the last input handshake (the last column, or the last C row when kc = 0), is high for exactly one cycle after that, and is low again the cycle after.
- R7: A job with kc = 0 leaves all of C equal to its preload.
- R8: After `done`, `c_out_valid` is high for exactly NR+kc accepted beats. Beats 0..NR-1 carry C row r with C[r][c] in bits [c*AW +: AW]. The block then returns to idle.
- R9: While `c_out_valid` is high and `c_out_ready` is low, the next cycle still has `c_out_valid` high and the same `c_out_data`.
- R10: Readout beat NR+k carries row k of Aᵀ: entry c is a_k[c], sign-extended to AW bits, in bits [c*AW +: AW]. This holds for every k up to KC_MAX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a job; taken only when idle |
| kc_len | input | KCW (5) | Panel width kc, 0..KC_MAX |
| c_in_valid | input | 1 | Preload row valid |
| c_in_ready | output | 1 | Preload row accepted |
| c_in_data | input | NR*AW (160) | One row of initial C |
| col_valid | input | 1 | Column of A valid |
| col_ready | output | 1 | Column of A accepted |
| col_data | input | NR*DW (64) | One column of A, signed entries |
| done | output | 1 | One-cycle pulse after the final update iteration |
| c_out_valid | output | 1 | Readout beat valid |
| c_out_ready | input | 1 | Readout beat accepted |
| c_out_data | output | NR*AW (160) | C row, then Aᵀ row |

## Verification
The hardest behaviour to reach from the ports is the lagged transpose under stalls. When `col_valid` drops mid-panel, the previous column must stay parked in the diagonal elements and nothing may accumulate twice. The drain iteration must still fire without any input, and it must fire exactly once. The stimulus inserts valid gaps into both input streams and irregular `c_out_ready` back-pressure on the output. It also runs a job with kc = 0, where the drain is the only iteration. A full-width panel at the extreme signed values exercises the wrap of the retention address and the widest products.

// File: rtl/rank_mesh_pkg.sv
package rank_mesh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_READ = 2'd3
  } phase_t;
endpackage

// File: rtl/mesh_seq.sv
module mesh_seq
  import rank_mesh_pkg::*;
#(
  parameter int NR     = 4,
  parameter int KC_MAX = 16,
  parameter int RW     = 2,
  parameter int DAW    = 2,
  parameter int KCW    = 5,
  parameter int CW     = 5
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [KCW-1:0] kc_len,
  input  logic           c_in_valid,
  output logic           c_in_ready,
  input  logic           col_valid,
  output logic           col_ready,
  output logic           c_out_valid,
  input  logic           c_out_ready,
  output logic           done,
  output logic           load_en,
  output logic [RW-1:0]  load_row,
  output logic           feed,
  output logic           upd,
  output logic [RW-1:0]  ret_row,
  output logic [DAW-1:0] ret_addr,
  output logic [RW-1:0]  rd_row,
  output logic [DAW-1:0] rd_addr,
  output logic           rd_at
);
  phase_t         phase;
  logic [KCW-1:0] kc_q;
  logic [CW-1:0]  iter;      // loop counter: iterations in RUN, beats in READ
  logic [CW-1:0]  kc_ext;
  logic           step, last_iter, last_beat, done_q;
  logic [RW-1:0]  row_q;

  assign kc_ext    = CW'(kc_q);
  assign step      = (phase == ST_RUN) && ((iter < kc_ext) ? col_valid : 1'b1);
  assign feed      = step && (iter < kc_ext);
  assign upd       = step && (iter != '0);
  assign last_iter = (iter == kc_ext);
  assign last_beat = (iter == kc_ext + CW'(NR - 1));

  assign c_in_ready  = (phase == ST_LOAD);
  assign col_ready   = (phase == ST_RUN) && (iter < kc_ext);
  assign c_out_valid = (phase == ST_READ);
  assign load_en     = c_in_valid && (phase == ST_LOAD);
  assign load_row    = row_q;
  assign rd_row      = row_q;
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= ST_IDLE;
      kc_q     <= '0;
      iter     <= '0;
      row_q    <= '0;
      rd_addr  <= '0;
      rd_at    <= 1'b0;
      ret_row  <= '0;
      ret_addr <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase)
        ST_IDLE: if (start) begin
          kc_q  <= kc_len;
          row_q <= '0;
          phase <= ST_LOAD;
        end
        ST_LOAD: if (c_in_valid) begin
          if (row_q == RW'(NR - 1)) begin
            row_q    <= '0;
            iter     <= '0;
            ret_row  <= '0;
            ret_addr <= '0;
            phase    <= ST_RUN;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        ST_RUN: if (step) begin
          iter <= iter + 1'b1;
          if (upd) begin
            if (ret_row == RW'(NR - 1)) begin
              ret_row  <= '0;
              ret_addr <= ret_addr + 1'b1;
            end else begin
              ret_row <= ret_row + 1'b1;
            end
          end
          if (last_iter) begin
            done_q  <= 1'b1;
            iter    <= '0;
            row_q   <= '0;
            rd_addr <= '0;
            rd_at   <= 1'b0;
            phase   <= ST_READ;
          end
        end
        ST_READ: if (c_out_ready) begin
          iter <= iter + 1'b1;
          if (row_q == RW'(NR - 1)) begin
            row_q <= '0;
            if (rd_at) rd_addr <= rd_addr + 1'b1;
            else       rd_at   <= 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
          end
          if (last_beat) phase <= ST_IDLE;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_iter_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_RUN) |-> (iter <= kc_ext));
  assert_kc_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_IDLE && start) |-> (kc_len <= KCW'(KC_MAX)));
endmodule

// File: rtl/mesh_pe.sv
module mesh_pe #(
  parameter int DW    = 16,
  parameter int AW    = 40,
  parameter int DEPTH = 4,
  parameter int DAW   = 2,
  parameter int RW    = 2,
  parameter int ROW   = 0,
  parameter int COL   = 0
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic [RW-1:0]  load_row,
  input  logic [AW-1:0]  load_val,
  input  logic           feed,
  input  logic [DW-1:0]  row_bus,
  input  logic           upd,
  input  logic [DW-1:0]  col_bus,
  input  logic [RW-1:0]  ret_row,
  input  logic [DAW-1:0] ret_addr,
  input  logic [DAW-1:0] rd_addr,
  output logic [DW-1:0]  held,
  output logic [AW-1:0]  acc,
  output logic [DW-1:0]  at_out
);
  localparam int PW = 2 * DW;

  logic          load_sel, ret_sel;
  logic [DW-1:0] at_mem [DEPTH];

  assign load_sel = load_en && (load_row == RW'(ROW));
  assign ret_sel  = upd && (ret_row == RW'(ROW));
  assign at_out   = at_mem[rd_addr];

  // copy of the row-bus value, kept for the next iteration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (feed) held <= row_bus;
  end

  // retained transpose: column-bus value of the lagged column
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++) at_mem[d] <= '0;
    end else if (ret_sel) begin
      at_mem[ret_addr] <= col_bus;
    end
  end

  generate
    if (ROW >= COL) begin : g_low
      logic signed [PW-1:0] prod;
      assign prod = PW'($signed(held)) * PW'($signed(col_bus));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        acc <= '0;
        else if (load_sel) acc <= load_val;
        else if (upd)      acc <= acc + AW'(prod);
      end
      assert_acc_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_sel && !upd) |=> $stable(acc));
    end else begin : g_up
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        acc <= '0;
        else if (load_sel) acc <= load_val;
      end
      assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_sel |=> $stable(acc));
    end
  endgenerate

  assert_held_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !feed |=> $stable(held));
endmodule

// File: rtl/rank_update_mesh.sv
module rank_update_mesh
  import rank_mesh_pkg::*;
#(
  parameter int NR     = 4,
  parameter int DW     = 16,
  parameter int AW     = 40,
  parameter int KC_MAX = 16,
  localparam int RW    = $clog2(NR),
  localparam int DEPTH = (KC_MAX + NR - 1) / NR,
  localparam int DAW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int KCW   = $clog2(KC_MAX + 1),
  localparam int CW    = $clog2(KC_MAX + NR + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KCW-1:0]   kc_len,
  input  logic             c_in_valid,
  output logic             c_in_ready,
  input  logic [NR*AW-1:0] c_in_data,
  input  logic             col_valid,
  output logic             col_ready,
  input  logic [NR*DW-1:0] col_data,
  output logic             done,
  output logic             c_out_valid,
  input  logic             c_out_ready,
  output logic [NR*AW-1:0] c_out_data
);
  logic           load_en, feed, upd, rd_at;
  logic [RW-1:0]  load_row, ret_row, rd_row;
  logic [DAW-1:0] ret_addr, rd_addr;

  logic [DW-1:0] row_bus [NR];
  logic [DW-1:0] col_bus [NR];
  logic [DW-1:0] held_w  [NR][NR];
  logic [AW-1:0] acc_w   [NR][NR];
  logic [DW-1:0] at_w    [NR][NR];

  mesh_seq #(
    .NR(NR), .KC_MAX(KC_MAX), .RW(RW), .DAW(DAW), .KCW(KCW), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .kc_len(kc_len),
    .c_in_valid(c_in_valid), .c_in_ready(c_in_ready),
    .col_valid(col_valid), .col_ready(col_ready),
    .c_out_valid(c_out_valid), .c_out_ready(c_out_ready), .done(done),
    .load_en(load_en), .load_row(load_row), .feed(feed), .upd(upd),
    .ret_row(ret_row), .ret_addr(ret_addr),
    .rd_row(rd_row), .rd_addr(rd_addr), .rd_at(rd_at)
  );

  generate
    for (genvar r = 0; r < NR; r++) begin : g_row
      assign row_bus[r] = col_data[r*DW +: DW];
      assign col_bus[r] = held_w[r][r];   // diagonal element drives column bus
      for (genvar c = 0; c < NR; c++) begin : g_col
        mesh_pe #(
          .DW(DW), .AW(AW), .DEPTH(DEPTH), .DAW(DAW), .RW(RW), .ROW(r), .COL(c)
        ) u_pe (
          .clk(clk), .rst_n(rst_n),
          .load_en(load_en), .load_row(load_row), .load_val(c_in_data[c*AW +: AW]),
          .feed(feed), .row_bus(row_bus[r]),
          .upd(upd), .col_bus(col_bus[c]),
          .ret_row(ret_row), .ret_addr(ret_addr), .rd_addr(rd_addr),
          .held(held_w[r][c]), .acc(acc_w[r][c]), .at_out(at_w[r][c])
        );
      end
    end
  endgenerate

  always_comb begin
    for (int c = 0; c < NR; c++) begin
      c_out_data[c*AW +: AW] = rd_at ? AW'($signed(at_w[rd_row][c])) : acc_w[rd_row][c];
    end
  end

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_out_valid && !c_out_ready) |=> (c_out_valid && $stable(c_out_data)));
  assert_phase_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_in_ready |-> (!col_ready && !c_out_valid));
endmodule

// File: tb/test_rank_update_mesh.sv
module test_rank_update_mesh;
  localparam int NR     = 4;
  localparam int DW     = 16;
  localparam int AW     = 40;
  localparam int KC_MAX = 16;
  localparam int KCW    = $clog2(KC_MAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             start = 1'b0;
  logic [KCW-1:0]   kc_len = '0;
  logic             c_in_valid = 1'b0;
  logic             c_in_ready;
  logic [NR*AW-1:0] c_in_data = '0;
  logic             col_valid = 1'b0;
  logic             col_ready;
  logic [NR*DW-1:0] col_data = '0;
  logic             done;
  logic             c_out_valid;
  logic             c_out_ready = 1'b0;
  logic [NR*AW-1:0] c_out_data;

  rank_update_mesh #(.NR(NR), .DW(DW), .AW(AW), .KC_MAX(KC_MAX)) i_rank_update_mesh (
    .clk(clk), .rst_n(rst_n), .start(start), .kc_len(kc_len),
    .c_in_valid(c_in_valid), .c_in_ready(c_in_ready), .c_in_data(c_in_data),
    .col_valid(col_valid), .col_ready(col_ready), .col_data(col_data),
    .done(done), .c_out_valid(c_out_valid), .c_out_ready(c_out_ready),
    .c_out_data(c_out_data)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit out_gaps = 1'b0;
  bit finished = 1'b0;
  string low_tag = "R4";
  string up_tag = "R5";

  logic [NR*AW-1:0] sb_data[$];
  int               sb_kind[$];
  longint           cpre [NR][NR];
  longint           amat [KC_MAX][NR];

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // output ready pattern, driven just after each edge
  always @(posedge clk) begin
    cyc++;
    #1 c_out_ready = out_gaps ? ((cyc % 3) != 0) : 1'b1;
  end

  // scoreboard monitor
  logic [NR*AW-1:0] hold_data;
  bit hold_pend = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk("R9", longint'(c_out_valid), 1, "valid held under back-pressure");
        chk("R9", longint'(c_out_data == hold_data), 1, "data held under back-pressure");
        hold_pend = 1'b0;
      end
      if (c_out_valid) begin
        if (c_out_ready) begin
          if (sb_data.size() == 0) begin
            chk("R8", 0, 1, "beat with empty scoreboard");
          end else begin
            logic [NR*AW-1:0] e;
            int kind;
            e = sb_data.pop_front();
            kind = sb_kind.pop_front();
            for (int c = 0; c < NR; c++) begin
              string t;
              if (kind < 0) t = "R10";
              else if (kind >= c) t = low_tag;
              else t = up_tag;
              chk(t, longint'(c_out_data[c*AW +: AW]), longint'(e[c*AW +: AW]),
                  $sformatf("beat kind %0d col %0d", kind, c));
            end
          end
        end else begin
          hold_pend = 1'b1;
          hold_data = c_out_data;
        end
      end
    end
  end

  task automatic put_row(input logic [NR*AW-1:0] d);
    c_in_valid = 1'b1;
    c_in_data = d;
    do @(negedge clk); while (!c_in_ready);
    @(posedge clk); #1;
    c_in_valid = 1'b0;
  endtask

  task automatic put_col(input logic [NR*DW-1:0] d);
    col_valid = 1'b1;
    col_data = d;
    do @(negedge clk); while (!col_ready);
    @(posedge clk); #1;
    col_valid = 1'b0;
  endtask

  // driver: computes expected beats, pushes them, then drives the job
  task automatic run_job(input int kc, input int seed, input bit gaps, input bit extreme);
    logic [NR*AW-1:0] w;
    logic [NR*DW-1:0] cd;
    longint e;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NR; c++)
        cpre[r][c] = longint'((r * 7 + c * 3 + seed) * 1000) - 9000;
    for (int k = 0; k < kc; k++)
      for (int r = 0; r < NR; r++)
        amat[k][r] = extreme ? (((k + r) % 2 == 1) ? -32768 : 32767)
                             : longint'(((k * 37 + r * 11 + seed * 5) % 200) - 100);
    low_tag = (kc == 0) ? "R7" : "R4";
    up_tag  = (kc == 0) ? "R7" : "R5";
    for (int r = 0; r < NR; r++) begin
      w = '0;
      for (int c = 0; c < NR; c++) begin
        e = cpre[r][c];
        if (r >= c) for (int k = 0; k < kc; k++) e += amat[k][r] * amat[k][c];
        w[c*AW +: AW] = AW'(e);
      end
      sb_data.push_back(w);
      sb_kind.push_back(r);
    end
    for (int k = 0; k < kc; k++) begin
      w = '0;
      for (int c = 0; c < NR; c++) w[c*AW +: AW] = AW'(amat[k][c]);
      sb_data.push_back(w);
      sb_kind.push_back(-1);
    end
    out_gaps = gaps;

    @(posedge clk); #1;
    start = 1'b1;
    kc_len = KCW'(kc);
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk("R2", longint'(c_in_ready), 1, "preload ready after start");
    chk("R3", longint'(col_ready), 0, "no column ready while loading");
    @(posedge clk); #1;
    for (int r = 0; r < NR; r++) begin
      if (gaps && (r % 2 == 1)) repeat (2) @(posedge clk);
      #0;
      w = '0;
      for (int c = 0; c < NR; c++) w[c*AW +: AW] = AW'(cpre[r][c]);
      put_row(w);
    end
    for (int k = 0; k < kc; k++) begin
      if (gaps && (k % 3 == 1)) repeat (3) @(posedge clk);
      cd = '0;
      for (int r = 0; r < NR; r++) cd[r*DW +: DW] = DW'(amat[k][r]);
      put_col(cd);
    end
    // R6: drain iteration, then a single-cycle done
    @(negedge clk);
    chk("R6", longint'(done), 0, "done during drain iteration");
    @(negedge clk);
    chk("R6", longint'(done), 1, "done after last iteration");
    @(negedge clk);
    chk("R6", longint'(done), 0, "done is one cycle");
    wait (sb_data.size() == 0);
    @(negedge clk);
    @(negedge clk);
    chk("R8", longint'(c_out_valid), 0, "no beats beyond NR+kc");
    chk("R8", longint'(c_in_ready), 0, "back to idle after readout");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog: actual no completion expected job end");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", longint'(done), 0, "done in reset");
    chk("R1", longint'(c_out_valid), 0, "out valid in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", longint'(c_in_ready), 0, "preload ready idle");
    chk("R1", longint'(col_ready), 0, "column ready idle");
    chk("R1", longint'(c_out_valid), 0, "out valid idle");
    chk("R1", longint'(done), 0, "done idle");
    @(posedge clk); #1;
    run_job(4, 1, 1'b0, 1'b0);
    run_job(7, 2, 1'b1, 1'b0);
    run_job(0, 3, 1'b1, 1'b0);
    run_job(KC_MAX, 4, 1'b0, 1'b1);
    run_job(9, 5, 1'b1, 1'b1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule